// File: doc/BRIEF.md
# Quasi-Bidirectional Port Latch

This block models one general-purpose port of a small controller, one bit per pin. Each pin has an output latch that drives a pull-down switch against a weak pull-up. Software can write the whole latch as a byte or set, clear or complement a single bit. A latch bit of 1 releases the pin, so an outside source can pull it low and the pin works as an input. A latch bit of 0 holds the pin low whatever the outside source does.

There are two read paths into a shared read register. The read-latch strobe returns the latch contents. Read-modify-write sequences use this path, so a pin that is heavily loaded is never taken for the value that was written. The read-pin strobe returns the pin level after a two-flop synchronizer. Plain input reads use this path.

On reset every latch bit is 1, so all pins are inputs at once. A pin whose bit was cleared stays an output until its bit is set again.

Top module: `qbd_port`

## Requirements
- R1: While reset is held and after it is released, every latch bit is 1, `rd_data` is 0 and `pin_lvl` equals `ext_drive`.
- R2: When `wr_en` is high, the latch takes `wr_data` at that clock edge.
- R3: When `bit_op_en` is high and `wr_en` is low, only latch bit `bit_sel` changes at the edge. The `bit_op` encoding is 2'b00 set, 2'b01 clear, 2'b10 complement and 2'b11 no change.
- R4: The complement operation inverts the latch bit and does not use the pin level. A latch bit of 1 on a pin held low from outside becomes 0.
- R5: `pin_lvl` equals the latch ANDed with `ext_drive`, so a cleared latch bit holds its pin low whatever `ext_drive` is.
- R6: A read-latch strobe loads `rd_data` with the latch value as it was before that edge, including when a write or bit operation happens in the same cycle.
- R7: A read-pin strobe loads `rd_data` with the pin level as it was two edges earlier. A change on `ext_drive` shows up on the third strobe edge after the change and not before.
- R8: When both read strobes are high in the same cycle, the latch read takes priority.
- R9: When `wr_en` and `bit_op_en` are high in the same cycle, the byte write takes priority and the bit operation is dropped.
- R10: A pin whose latch bit was cleared reads back as low on the pin path until its bit is set; after that it follows `ext_drive` again.
- R11: Without a read strobe, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write enable |
| wr_data | input | 8 | Byte to load into the latch |
| bit_op_en | input | 1 | Single-bit operation enable |
| bit_op | input | 2 | 00 set, 01 clear, 10 complement, 11 no change |
| bit_sel | input | 3 | Index of the bit to operate on |
| rd_latch_en | input | 1 | Read-latch strobe |
| rd_pin_en | input | 1 | Read-pin strobe |
| ext_drive | input | 8 | Outside source per pin, 0 pulls the pin low |
| pin_lvl | output | 8 | Resulting pin level |
| rd_data | output | 8 | Result of the last read |

## Verification
The risky overlap is a read-latch strobe in the same cycle as a byte write or bit update. The read must return the old latch value while the latch takes the new one. The bench drives both in one cycle, checks `rd_data` against the old value, then reads again to confirm the new value. It also drives a byte write together with a bit operation, and both read strobes together, and judges each result against the stated priority.

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int W = 8,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_op_en,
  input  logic [1:0]    bit_op,
  input  logic [SW-1:0] bit_sel,
  input  logic          rd_latch_en,
  input  logic          rd_pin_en,
  input  logic [W-1:0]  ext_drive,
  output logic [W-1:0]  pin_lvl,
  output logic [W-1:0]  rd_data
);

  localparam logic [1:0] OP_SET = 2'b00;
  localparam logic [1:0] OP_CLR = 2'b01;
  localparam logic [1:0] OP_CPL = 2'b10;

  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] sync1_q, sync2_q;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) begin
      latch_d = wr_data;
    end else if (bit_op_en) begin
      unique case (bit_op)
        OP_SET:  latch_d[bit_sel] = 1'b1;
        OP_CLR:  latch_d[bit_sel] = 1'b0;
        OP_CPL:  latch_d[bit_sel] = ~latch_q[bit_sel];
        default: latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else        latch_q <= latch_d;
  end

  assign pin_lvl = latch_q & ext_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pin_lvl;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_data <= '0;
    else if (rd_latch_en) rd_data <= latch_q;
    else if (rd_pin_en)   rd_data <= sync2_q;
  end

  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_q == $past(wr_data));

  p_clear_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_op_en && !wr_en && bit_op == OP_CLR) |=> !pin_lvl[$past(bit_sel)]);

  p_cpl_inverts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_op_en && !wr_en && bit_op == OP_CPL)
      |=> latch_q[$past(bit_sel)] != $past(latch_q[bit_sel]));

  p_read_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_en |=> rd_data == $past(latch_q));

  p_read_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin_en && !rd_latch_en) |=> rd_data == $past(sync2_q));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));

endmodule

// File: tb/tb_qbd_port.sv
module tb_qbd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_op_en = 1'b0;
  logic [1:0] bit_op = 2'b11;
  logic [2:0] bit_sel = '0;
  logic       rd_latch_en = 1'b0;
  logic       rd_pin_en = 1'b0;
  logic [7:0] ext_drive = 8'hFF;
  logic [7:0] pin_lvl, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qbd_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_op_en(bit_op_en), .bit_op(bit_op), .bit_sel(bit_sel),
    .rd_latch_en(rd_latch_en), .rd_pin_en(rd_pin_en),
    .ext_drive(ext_drive), .pin_lvl(pin_lvl), .rd_data(rd_data)
  );

  // {write byte, outside drive, expected pin level}
  localparam logic [23:0] VEC [0:5] = '{
    {8'hA5, 8'hFF, 8'hA5},
    {8'hFF, 8'h3C, 8'h3C},
    {8'h0F, 8'hF0, 8'h00},
    {8'h00, 8'hFF, 8'h00},
    {8'hC3, 8'h81, 8'h81},
    {8'hFF, 8'hFF, 8'hFF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic do_bit(input logic [1:0] op, input logic [2:0] sel);
    bit_op_en = 1'b1; bit_op = op; bit_sel = sel; tick(); bit_op_en = 1'b0;
  endtask

  task automatic read_latch();
    rd_latch_en = 1'b1; tick(); rd_latch_en = 1'b0;
  endtask

  task automatic read_pin_settled();
    tick(); tick(); tick();
    rd_pin_en = 1'b1; tick(); rd_pin_en = 1'b0;
  endtask

  initial begin
    #300000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ext_drive = 8'h5A;
    #23;
    check("R1 rd_data in reset", rd_data, 8'h00);
    check("R1 pin follows drive in reset", pin_lvl, 8'h5A);
    rst_n = 1'b1;
    tick();
    read_latch();
    check("R1 latch all ones", rd_data, 8'hFF);

    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i][23:16]);
      ext_drive = VEC[i][15:8];
      #1;
      check("R5 pin level", pin_lvl, VEC[i][7:0]);
      read_latch();
      check("R2 latch read", rd_data, VEC[i][23:16]);
      read_pin_settled();
      check("R7 pin read", rd_data, VEC[i][7:0]);
    end

    ext_drive = 8'hFF;
    do_write(8'h00);
    do_bit(2'b00, 3'd5);
    read_latch();
    check("R3 set bit 5", rd_data, 8'h20);
    do_write(8'hFF);
    do_bit(2'b01, 3'd5);
    read_latch();
    check("R3 clear bit 5", rd_data, 8'hDF);
    do_bit(2'b11, 3'd2);
    read_latch();
    check("R3 no-change code", rd_data, 8'hDF);

    do_write(8'hFF);
    ext_drive = 8'hFE;
    #1;
    check("R5 pin 0 pulled low", pin_lvl, 8'hFE);
    do_bit(2'b10, 3'd0);
    read_latch();
    check("R4 complement uses latch", rd_data, 8'hFE);

    ext_drive = 8'hFF;
    do_write(8'hFF);
    do_bit(2'b01, 3'd3);
    #1;
    check("R5 cleared bit forces low", pin_lvl, 8'hF7);
    read_pin_settled();
    check("R10 cleared pin reads low", rd_data, 8'hF7);
    do_bit(2'b00, 3'd3);
    read_pin_settled();
    check("R10 pin usable after set", rd_data, 8'hFF);

    do_write(8'h55);
    wr_en = 1'b1; wr_data = 8'hAA; rd_latch_en = 1'b1;
    tick();
    wr_en = 1'b0; rd_latch_en = 1'b0;
    check("R6 coincident read old value", rd_data, 8'h55);
    read_latch();
    check("R6 new value after write", rd_data, 8'hAA);

    do_write(8'h00);
    wr_en = 1'b1; wr_data = 8'h3C; bit_op_en = 1'b1; bit_op = 2'b00; bit_sel = 3'd7;
    tick();
    wr_en = 1'b0; bit_op_en = 1'b0;
    read_latch();
    check("R9 write beats bit op", rd_data, 8'h3C);

    do_write(8'hFF);
    ext_drive = 8'h0F;
    tick(); tick(); tick();
    rd_latch_en = 1'b1; rd_pin_en = 1'b1;
    tick();
    rd_latch_en = 1'b0; rd_pin_en = 1'b0;
    check("R8 latch read has priority", rd_data, 8'hFF);

    ext_drive = 8'h00;
    read_pin_settled();
    check("R7 settled low", rd_data, 8'h00);
    ext_drive = 8'hFF;
    rd_pin_en = 1'b1;
    tick();
    check("R7 first edge stale", rd_data, 8'h00);
    tick();
    check("R7 second edge stale", rd_data, 8'h00);
    tick();
    check("R7 third edge updated", rd_data, 8'hFF);
    rd_pin_en = 1'b0;

    ext_drive = 8'h00;
    tick(); tick(); tick();
    check("R11 rd_data holds", rd_data, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule